// File: doc/BRIEF.md
# Downstream Lookup Credit and Stalled-Port Retry Queue

This block limits how many translation lookups can be in flight toward the next level of the hierarchy. A credit counter rises by one on each issue pulse and falls by one on each completion pulse. The number of free slots is the configured maximum minus that count, and it is visible on an output.

Requester ports raise a request line when they want a slot. A port is refused with a stall indication in two cases: no slot is free, or other ports are already waiting. A refused port joins a first-in first-out stall queue. A membership bit vector keeps any port from holding more than one place in that queue. If a port is refused again while it is still waiting, nothing is added. On every cycle that has a free slot and a non-empty queue, the oldest waiting port leaves the queue, its membership bit clears, and it receives a one-cycle retry pulse. When no slot is free, no port is woken.

Top module: `lookup_credit_gate`

## Requirements
- R1: After reset the free-slot output equals MAX_OUT, the stall queue is empty, and no retry or stall is asserted while requests are made.
- R2: An issue pulse without a completion lowers the free-slot count by one on the next cycle. Issuing with no free slot is forbidden.
- R3: A completion pulse without an issue raises the free-slot count by one on the next cycle. Completing with nothing outstanding is forbidden.
- R4: An issue and a completion in the same cycle leave the free-slot count unchanged.
- R5: A requesting port sees stall asserted in the same cycle whenever the free-slot count is zero.
- R6: A requesting port sees stall asserted whenever the stall queue is non-empty, even when slots are free.
- R7: A refused port is queued only if its membership bit is clear. A second refusal while it is queued adds no entry.
- R8: Retries go out in the order the ports were refused. Ports refused in the same cycle are ordered by ascending index (bit 0 first).
- R9: At most one retry bit is high per cycle. Retry is a one-cycle pulse on bit p of the retry vector for port p, and the port leaves the queue at that point.
- R10: No retry is issued in a cycle whose free-slot count is zero, even when ports are waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_PORTS | Per-port request for a downstream slot |
| issue_i | input | 1 | One lookup sent downstream this cycle |
| complete_i | input | 1 | One outstanding lookup finished this cycle |
| stall_o | output | N_PORTS | Per-port refusal, valid in the cycle of the request |
| retry_o | output | N_PORTS | Per-port one-cycle wake-up pulse |
| free_slots_o | output | CW | Free slots, MAX_OUT minus outstanding count |

## Verification
Assertions check the credit bounds on every cycle: no issue at full occupancy and no completion at zero. They also check that no already-queued port is pushed a second time, that the queue never pops while empty or grows past the port count, and that the retry vector is never multi-hot. The queue order itself is shown only by the bench scenarios: the wake-up order after staggered and simultaneous refusals, that duplicates are absent after a repeated refusal, that stalls hold while others wait even with slots free, and that the retry sequence pauses at zero slots.

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          complete_i,
  output logic [CW-1:0] free_o
);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (issue_i && !complete_i) count_q <= count_q + 1'b1;
    else if (complete_i && !issue_i) count_q <= count_q - 1'b1;
  end

  assign free_o = CW'(MAX_OUT) - count_q;

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !complete_i) |-> (count_q < CW'(MAX_OUT)));

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_i && !issue_i) |-> (count_q != '0));
endmodule

// File: rtl/unique_stall_fifo.sv
module unique_stall_fifo #(
  parameter int N_PORTS = 4,
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int NW = $clog2(N_PORTS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] push_i,
  input  logic               pop_i,
  output logic [IW-1:0]      head_o,
  output logic               empty_o,
  output logic [N_PORTS-1:0] member_o
);
  logic [IW-1:0]      slot_q [N_PORTS];
  logic [IW-1:0]      slot_d [N_PORTS];
  logic [IW-1:0]      rd_q, rd_d, wr_q, wr_d;
  logic [NW-1:0]      cnt_q, cnt_d;
  logic [N_PORTS-1:0] member_q, member_d, pop_mask;

  assign head_o   = slot_q[rd_q];
  assign empty_o  = (cnt_q == '0);
  assign member_o = member_q;

  always_comb begin
    pop_mask = '0;
    if (pop_i) pop_mask[head_o] = 1'b1;
  end

  // Ascending port index sets the order among pushes in one cycle.
  always_comb begin
    int rank;
    rank = 0;
    for (int i = 0; i < N_PORTS; i++) slot_d[i] = slot_q[i];
    for (int p = 0; p < N_PORTS; p++) begin
      if (push_i[p]) begin
        slot_d[(int'(wr_q) + rank) % N_PORTS] = IW'(p);
        rank++;
      end
    end
    wr_d     = IW'((int'(wr_q) + rank) % N_PORTS);
    rd_d     = pop_i ? IW'((int'(rd_q) + 1) % N_PORTS) : rd_q;
    cnt_d    = NW'(int'(cnt_q) + rank - (pop_i ? 1 : 0));
    member_d = (member_q & ~pop_mask) | push_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_PORTS; i++) slot_q[i] <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      cnt_q    <= '0;
      member_q <= '0;
    end else begin
      for (int i = 0; i < N_PORTS; i++) slot_q[i] <= slot_d[i];
      rd_q     <= rd_d;
      wr_q     <= wr_d;
      cnt_q    <= cnt_d;
      member_q <= member_d;
    end
  end

  assert_unique_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i & member_q & ~pop_mask) == '0);

  assert_no_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));

  assert_depth_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= N_PORTS);
endmodule

// File: rtl/lookup_credit_gate.sv
module lookup_credit_gate #(
  parameter int N_PORTS = 4,
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(MAX_OUT + 1),
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] req_i,
  input  logic               issue_i,
  input  logic               complete_i,
  output logic [N_PORTS-1:0] stall_o,
  output logic [N_PORTS-1:0] retry_o,
  output logic [CW-1:0]      free_slots_o
);
  logic [CW-1:0]      free_w;
  logic [IW-1:0]      head_w;
  logic               empty_w, must_stall, pop_w;
  logic [N_PORTS-1:0] member_w, push_w;

  credit_counter #(.MAX_OUT(MAX_OUT)) u_credit (
    .clk_i, .rst_ni, .issue_i, .complete_i, .free_o(free_w)
  );

  assign must_stall = !empty_w || (free_w == '0);
  assign stall_o    = must_stall ? req_i : '0;
  assign pop_w      = !empty_w && (free_w != '0);

  always_comb begin
    retry_o = '0;
    if (pop_w) retry_o[head_w] = 1'b1;
  end

  // A port leaving the queue this cycle may rejoin at the tail.
  assign push_w = stall_o & ~(member_w & ~retry_o);

  unique_stall_fifo #(.N_PORTS(N_PORTS)) u_queue (
    .clk_i, .rst_ni, .push_i(push_w), .pop_i(pop_w),
    .head_o(head_w), .empty_o(empty_w), .member_o(member_w)
  );

  assign free_slots_o = free_w;

  assert_retry_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(retry_o));

  assert_retry_member_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o & ~member_w) == '0);
endmodule

// File: tb/tb_lookup_credit_gate.sv
module tb_lookup_credit_gate;
  localparam int NP = 4;
  localparam int MX = 4;
  localparam int CW = $clog2(MX + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] req_i = '0;
  logic          issue_i = 1'b0, complete_i = 1'b0;
  logic [NP-1:0] stall_o, retry_o;
  logic [CW-1:0] free_slots_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lookup_credit_gate #(.N_PORTS(NP), .MAX_OUT(MX)) dut (
    .clk_i(clk), .rst_ni, .req_i, .issue_i, .complete_i,
    .stall_o, .retry_o, .free_slots_o
  );

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Apply inputs after a falling edge and let them settle.
  task automatic drive(logic [NP-1:0] rq, logic is, logic cp);
    @(negedge clk);
    req_i = rq; issue_i = is; complete_i = cp;
    #1;
  endtask

  task automatic t_reset();
    drive(4'b1111, 0, 0);
    chk("R1 free", 8'(free_slots_o), 8'(MX));
    chk("R1 stall", 8'(stall_o), 8'h0);
    chk("R1 retry", 8'(retry_o), 8'h0);
  endtask

  task automatic t_credit();
    drive(0, 1, 0);
    drive(0, 0, 0);
    chk("R2 free after issue", 8'(free_slots_o), 8'(MX - 1));
    drive(0, 1, 1);
    drive(0, 0, 0);
    chk("R4 free after issue+complete", 8'(free_slots_o), 8'(MX - 1));
    drive(0, 0, 1);
    drive(0, 0, 0);
    chk("R3 free after complete", 8'(free_slots_o), 8'(MX));
  endtask

  task automatic t_dedup_order();
    for (int i = 0; i < MX; i++) drive(0, 1, 0);
    drive(4'b0100, 0, 0);
    chk("R5 free zero", 8'(free_slots_o), 8'h0);
    chk("R5 stall at zero slots", 8'(stall_o), 8'b0100);
    drive(4'b0001, 0, 0);
    chk("R5 stall port0", 8'(stall_o), 8'b0001);
    drive(4'b0100, 0, 0);
    chk("R7 repeat refusal stalled", 8'(stall_o), 8'b0100);
    chk("R10 no retry at zero slots", 8'(retry_o), 8'h0);
    drive(0, 0, 0);
    chk("R10 still no retry", 8'(retry_o), 8'h0);
    drive(0, 0, 1);
    chk("R10 no retry in completion cycle", 8'(retry_o), 8'h0);
    drive(0, 0, 0);
    chk("R8 first retry port2", 8'(retry_o), 8'b0100);
    drive(0, 0, 0);
    chk("R8 second retry port0", 8'(retry_o), 8'b0001);
    drive(0, 0, 0);
    chk("R7 no duplicate entry", 8'(retry_o), 8'h0);
    chk("R9 slot count kept", 8'(free_slots_o), 8'h1);
  endtask

  task automatic t_same_cycle();
    drive(0, 1, 0);
    drive(4'b1010, 0, 0);
    chk("R5 two ports stalled", 8'(stall_o), 8'b1010);
    drive(0, 0, 1);
    drive(4'b0001, 0, 0);
    chk("R8 lower index first", 8'(retry_o), 8'b0010);
    chk("R6 stall with slot free", 8'(stall_o), 8'b0001);
    drive(0, 0, 0);
    chk("R8 then port3", 8'(retry_o), 8'b1000);
    drive(0, 0, 0);
    chk("R8 late refusal last", 8'(retry_o), 8'b0001);
    drive(0, 0, 0);
    chk("R9 queue drained", 8'(retry_o), 8'h0);
    drive(4'b0010, 0, 0);
    chk("R6 empty queue with slot, no stall", 8'(stall_o), 8'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_credit();
        t_dedup_order();
        t_same_cycle();
      end
      begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule